// File: doc/BRIEF.md
# Mixed-Access Control Register Bank

This block is a bank of 32-bit control and status registers reached through a small memory-mapped request/response port. Each request carries a byte offset, an access size in bytes (4 or 8), a write flag and 64 bits of write data. Every request gets exactly one response, one cycle after it is accepted. The response carries 64 bits of read data and an error flag.

Each register has a fixed write policy chosen by its index:

- plain read/write;
- read-only;
- write-one-to-clear;
- write-one-to-set.

The upper part of the bank is a scratchpad window. Only inside this window may an 8-byte access touch two neighbouring registers at once, in little-endian order. Paired writes store both halves directly, without any write policy.

A checker in front of the array decides whether each request is legal from its offset, its size and its alignment. A rejected request changes no register and answers with the error flag set. A 4-byte write to a read-only register is also answered with the error flag.

Both directions use valid/ready handshakes:

- A request transfers on a clock edge where `req_valid` and `req_ready` are both high.
- `req_ready` is high whenever no response is pending, or the pending response is being taken in the same cycle.
- A response transfers on an edge where `rsp_valid` and `rsp_ready` are both high.
- While `rsp_valid` is high and `rsp_ready` is low, the response data and error flag hold still, and no new request is accepted.

Top module: `ctlreg_bank`

## Requirements
- R1: On synchronous reset, `rsp_valid` goes low and the registers load these values:
  - index 0 = 0xA5C30107 (read-only);
  - index 1 = 0x00003C21 (read-only);
  - index 2 = 0x00000080 (read-only);
  - index 3 = 0x00000003 (write-one-to-clear);
  - index 4 = 0x000000F0 (write-one-to-clear);
  - index 5 = 0x00000000 (write-one-to-set);
  - index 6 = 0x00000002 (write-one-to-set);
  - index 7 = 0x12345678 (read/write);
  - indices 8 to 16 = 0 (read/write scratchpad).

  Register N sits at byte offset 4*N.
- R2: A request whose `req_size` is neither 4 nor 8 is rejected: `rsp_err`=1, read data 0, and no register changes.
- R3: A 4-byte access with `req_offset[1:0]`≠0, or an 8-byte access with `req_offset[2:0]`≠0, is rejected in the same way as R2.
- R4: A request with `req_offset` ≥ 4×NUM_REGS (0x44 by default) is rejected. A read at such an offset returns 0.
- R5: An 8-byte access is accepted only when its register index N satisfies PAD_FIRST ≤ N ≤ NUM_REGS-2 (indices 8 to 15 by default). This keeps the upper register N+1 inside the bank. Outside that range the 8-byte access is rejected. For example, 8 bytes at 0x18 or at 0x40 is rejected.
- R6: An accepted 8-byte read returns register N in bits 31:0 and register N+1 in bits 63:32, with `rsp_err`=0.
- R7: An accepted 8-byte write stores `req_wdata[31:0]` into register N and `req_wdata[63:32]` into register N+1, unchanged.
- R8: A 4-byte write to a read-only register (indices 0 to 2) leaves it unchanged and responds with `rsp_err`=1.
- R9: A 4-byte write to a write-one-to-clear register (indices 3, 4) stores old & ~`req_wdata[31:0]`, so its bits never go from 0 to 1.
- R10: A 4-byte write to a write-one-to-set register (indices 5, 6) stores old | `req_wdata[31:0]`, so its bits never go from 1 to 0.
- R11: A 4-byte write to a read/write register stores `req_wdata[31:0]`. A 4-byte read returns the register in bits 31:0 and zero in bits 63:32. Every accepted access other than an R8 write responds with `rsp_err`=0.
- R12: The response appears with `rsp_valid`=1 on the edge after acceptance. `req_ready` equals !`rsp_valid` | `rsp_ready`. While `rsp_valid`=1 and `rsp_ready`=0, `rsp_rdata` and `rsp_err` stay stable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | ADDR_W | Byte offset of the access |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data (bits 31:0 used for 4-byte writes) |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_rdata | output | 64 | Read data, zero for writes and rejected requests |
| rsp_err | output | 1 | Request rejected, or write to a read-only register |

## Verification
The main function is tried with several kinds of write pattern:

- Writes of all ones, single bits and zero to each policy class show whether clear, set, ignore and plain store are applied to the right index.
- An 8-byte write with distinct halves, read back both as one pair and as two separate words, separates the lane order from a swapped or duplicated half.

The checker is then probed from both sides of each boundary:

- the first and last legal pair index against the pair below the window and at the last register;
- the last register against the first offset past the bank;
- each illegal size and misalignment.

A read-back after each of these shows that nothing was written.

Back-pressure is applied by holding `rsp_ready` low across several cycles. This shows both that the response holds still and that no request is accepted while it waits.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  typedef enum logic [1:0] {
    POL_RW  = 2'd0,
    POL_RO  = 2'd1,
    POL_W1C = 2'd2,
    POL_W1S = 2'd3
  } pol_e;

  localparam logic [3:0] SZ_WORD = 4'd4;
  localparam logic [3:0] SZ_PAIR = 4'd8;

  // Write policy by register index; everything above the fixed set is plain storage.
  function automatic pol_e pol_of(input int idx);
    case (idx)
      0, 1, 2: pol_of = POL_RO;
      3, 4:    pol_of = POL_W1C;
      5, 6:    pol_of = POL_W1S;
      default: pol_of = POL_RW;
    endcase
  endfunction

  // Cold-reset value by register index.
  function automatic logic [31:0] rst_of(input int idx);
    case (idx)
      0:       rst_of = 32'hA5C3_0107;
      1:       rst_of = 32'h0000_3C21;
      2:       rst_of = 32'h0000_0080;
      3:       rst_of = 32'h0000_0003;
      4:       rst_of = 32'h0000_00F0;
      5:       rst_of = 32'h0000_0000;
      6:       rst_of = 32'h0000_0002;
      7:       rst_of = 32'h1234_5678;
      default: rst_of = 32'h0000_0000;
    endcase
  endfunction

endpackage

// File: rtl/ctlreg_access_check.sv
module ctlreg_access_check
  import ctlreg_pkg::*;
#(
  parameter int NUM_REGS  = 17,
  parameter int PAD_FIRST = 8,
  parameter int ADDR_W    = 8,
  localparam int IW       = ADDR_W - 2
) (
  input  logic [ADDR_W-1:0] offset,
  input  logic [3:0]        size,
  input  logic              is_write,
  output logic [IW-1:0]     idx,
  output logic              is_pair,
  output logic              accept,
  output logic              ro_hit
);

  localparam logic [ADDR_W:0] LIMIT_V = (ADDR_W+1)'(NUM_REGS * 4);
  localparam logic [IW-1:0]   PAD_LO  = IW'(PAD_FIRST);
  localparam logic [IW-1:0]   PAD_HI  = IW'(NUM_REGS - 2);

  logic size_word, size_pair, in_range, aligned, window_ok;

  always_comb begin
    idx       = offset[ADDR_W-1:2];
    size_word = (size == SZ_WORD);
    size_pair = (size == SZ_PAIR);
    in_range  = ({1'b0, offset} < LIMIT_V);
    aligned   = size_pair ? (offset[2:0] == 3'd0) : (offset[1:0] == 2'd0);
    window_ok = !size_pair || ((idx >= PAD_LO) && (idx <= PAD_HI));
    is_pair   = size_pair;
    accept    = (size_word || size_pair) && in_range && aligned && window_ok;
    ro_hit    = accept && is_write && size_word && (pol_of(int'(idx)) == POL_RO);
  end

  // R5: an accepted pair never names the last register as its lower half
  always_comb begin
    a_pair_upper_exists_r5 : assert (!(accept && is_pair) || (idx < IW'(NUM_REGS - 1)));
  end

endmodule

// File: rtl/ctlreg_cell.sv
module ctlreg_cell
  import ctlreg_pkg::*;
#(
  parameter pol_e        POL     = POL_RW,
  parameter logic [31:0] RST_VAL = 32'h0
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_word,
  input  logic        wr_pair,
  input  logic [31:0] wdata,
  output logic [31:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= RST_VAL;
    end else if (wr_pair) begin
      q <= wdata;
    end else if (wr_word) begin
      case (POL)
        POL_RW:  q <= wdata;
        POL_W1C: q <= q & ~wdata;
        POL_W1S: q <= q | wdata;
        default: q <= q;
      endcase
    end
  end

  generate
    if (POL == POL_RO) begin : g_ro
      p_ro_hold_r8 : assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(q));
    end else if (POL == POL_W1C) begin : g_w1c
      p_w1c_no_rise_r9 : assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((q & ~$past(q)) == 32'h0));
    end else if (POL == POL_W1S) begin : g_w1s
      p_w1s_no_fall_r10 : assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((q & $past(q)) == $past(q)));
    end else begin : g_rw
      p_rw_store_r11 : assert property (@(posedge clk) disable iff (rst)
        (wr_word && !wr_pair) |=> (q == $past(wdata)));
    end
  endgenerate

endmodule

// File: rtl/ctlreg_rsp_stage.sv
module ctlreg_rsp_stage #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] ld_data,
  input  logic          ld_err,
  input  logic          rsp_ready,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic          free
);

  assign free = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
      rsp_err   <= 1'b0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= ld_data;
      rsp_err   <= ld_err;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  p_hold_r12 : assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));

  p_latency_r12 : assert property (@(posedge clk) disable iff (rst)
    load |=> rsp_valid);

endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
#(
  parameter int NUM_REGS  = 17,
  parameter int PAD_FIRST = 8,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_offset,
  input  logic [3:0]        req_size,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_err
);

  localparam int IW = ADDR_W - 2;

  logic [IW-1:0] idx, idx_hi;
  logic          is_pair, accept, ro_hit, fire, wr_ok;
  logic [31:0]   regs [NUM_REGS];
  logic [31:0]   rd_lo, rd_hi;
  logic [63:0]   rd_data;

  ctlreg_access_check #(
    .NUM_REGS (NUM_REGS),
    .PAD_FIRST(PAD_FIRST),
    .ADDR_W   (ADDR_W)
  ) u_check (
    .offset  (req_offset),
    .size    (req_size),
    .is_write(req_write),
    .idx     (idx),
    .is_pair (is_pair),
    .accept  (accept),
    .ro_hit  (ro_hit)
  );

  assign fire   = req_valid && req_ready;
  assign wr_ok  = fire && req_write && accept;
  assign idx_hi = idx + IW'(1);

  generate
    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
      logic hit_lo, hit_hi;
      assign hit_lo = (idx == IW'(i));
      assign hit_hi = is_pair && (idx_hi == IW'(i));
      ctlreg_cell #(
        .POL    (pol_of(i)),
        .RST_VAL(rst_of(i))
      ) u_cell (
        .clk    (clk),
        .rst    (rst),
        .wr_word(wr_ok && !is_pair && hit_lo),
        .wr_pair(wr_ok && is_pair && (hit_lo || hit_hi)),
        .wdata  (hit_hi ? req_wdata[63:32] : req_wdata[31:0]),
        .q      (regs[i])
      );
    end
  endgenerate

  always_comb begin
    rd_lo = '0;
    rd_hi = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx == IW'(i))                rd_lo = regs[i];
      if (is_pair && idx_hi == IW'(i))  rd_hi = regs[i];
    end
    rd_data = (accept && !req_write) ? {rd_hi, rd_lo} : 64'h0;
  end

  ctlreg_rsp_stage #(.DW(64)) u_rsp (
    .clk      (clk),
    .rst      (rst),
    .load     (fire),
    .ld_data  (rd_data),
    .ld_err   (!accept || ro_hit),
    .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_rdata),
    .rsp_err  (rsp_err),
    .free     (req_ready)
  );

  p_ready_r12 : assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |-> !req_ready);

  p_bad_size_r2 : assert property (@(posedge clk) disable iff (rst)
    (fire && req_size != 4'd4 && req_size != 4'd8) |=> (rsp_err && rsp_rdata == 64'h0));

  p_misalign_r3 : assert property (@(posedge clk) disable iff (rst)
    (fire && req_offset[1:0] != 2'd0) |=> rsp_err);

  p_out_of_range_r4 : assert property (@(posedge clk) disable iff (rst)
    (fire && ({1'b0, req_offset} >= (ADDR_W+1)'(NUM_REGS * 4))) |=> (rsp_err && rsp_rdata == 64'h0));

  p_pair_below_window_r5 : assert property (@(posedge clk) disable iff (rst)
    (fire && req_size == 4'd8 && req_offset < ADDR_W'(PAD_FIRST * 4)) |=> rsp_err);

  p_ro_write_err_r8 : assert property (@(posedge clk) disable iff (rst)
    (fire && req_write && req_size == 4'd4 && req_offset == '0) |=> rsp_err);

  p_word_read_upper_zero_r11 : assert property (@(posedge clk) disable iff (rst)
    (fire && !req_write && req_size == 4'd4) |=> (rsp_rdata[63:32] == 32'h0));

endmodule

// File: tb/ctlreg_bank_bench.sv
module ctlreg_bank_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid, req_write, rsp_ready;
  logic        req_ready, rsp_valid, rsp_err;
  logic [7:0]  req_offset;
  logic [3:0]  req_size;
  logic [63:0] req_wdata, rsp_rdata;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  ctlreg_bank u_ctlreg_bank (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_offset(req_offset),
    .req_size  (req_size),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

  typedef struct packed {
    logic        wr;
    logic [7:0]  off;
    logic [3:0]  size;
    logic [63:0] wdata;
    logic        err;
    logic [63:0] rdata;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 4'd4, 64'h0, 1'b0, 64'h0000_0000_A5C3_0107, 4'd1},    // R1
    '{1'b0, 8'h18, 4'd4, 64'h0, 1'b0, 64'h0000_0000_0000_0002, 4'd1},    // R1
    '{1'b1, 8'h00, 4'd4, 64'hFFFF_FFFF, 1'b1, 64'h0, 4'd8},              // R8
    '{1'b0, 8'h00, 4'd4, 64'h0, 1'b0, 64'h0000_0000_A5C3_0107, 4'd8},    // R8
    '{1'b1, 8'h0C, 4'd4, 64'h1, 1'b0, 64'h0, 4'd9},                      // R9
    '{1'b0, 8'h0C, 4'd4, 64'h0, 1'b0, 64'h2, 4'd9},                      // R9
    '{1'b1, 8'h18, 4'd4, 64'h10, 1'b0, 64'h0, 4'd10},                    // R10
    '{1'b1, 8'h18, 4'd4, 64'h0, 1'b0, 64'h0, 4'd10},                     // R10
    '{1'b0, 8'h18, 4'd4, 64'h0, 1'b0, 64'h12, 4'd10},                    // R10
    '{1'b1, 8'h1C, 4'd4, 64'hCAFE_F00D, 1'b0, 64'h0, 4'd11},             // R11
    '{1'b0, 8'h1C, 4'd4, 64'h0, 1'b0, 64'hCAFE_F00D, 4'd11},             // R11
    '{1'b1, 8'h20, 4'd8, 64'h1122_3344_5566_7788, 1'b0, 64'h0, 4'd7},    // R7
    '{1'b0, 8'h20, 4'd8, 64'h0, 1'b0, 64'h1122_3344_5566_7788, 4'd6},    // R6
    '{1'b0, 8'h24, 4'd4, 64'h0, 1'b0, 64'h1122_3344, 4'd7},              // R7
    '{1'b0, 8'h20, 4'd4, 64'h0, 1'b0, 64'h5566_7788, 4'd7},              // R7
    '{1'b1, 8'h18, 4'd8, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 64'h0, 4'd5},   // R5
    '{1'b0, 8'h18, 4'd4, 64'h0, 1'b0, 64'h12, 4'd5},                     // R5
    '{1'b0, 8'h40, 4'd8, 64'h0, 1'b1, 64'h0, 4'd5},                      // R5
    '{1'b1, 8'h38, 4'd8, 64'hDEAD_BEEF_0BAD_F00D, 1'b0, 64'h0, 4'd5},   // R5
    '{1'b0, 8'h3C, 4'd4, 64'h0, 1'b0, 64'hDEAD_BEEF, 4'd5},              // R5
    '{1'b0, 8'h24, 4'd8, 64'h0, 1'b1, 64'h0, 4'd3},                      // R3
    '{1'b1, 8'h22, 4'd4, 64'hFFFF_FFFF, 1'b1, 64'h0, 4'd3},              // R3
    '{1'b0, 8'h1E, 4'd4, 64'h0, 1'b1, 64'h0, 4'd3},                      // R3
    '{1'b0, 8'h20, 4'd2, 64'h0, 1'b1, 64'h0, 4'd2},                      // R2
    '{1'b1, 8'h20, 4'd1, 64'hFF, 1'b1, 64'h0, 4'd2},                     // R2
    '{1'b0, 8'h20, 4'd4, 64'h0, 1'b0, 64'h5566_7788, 4'd2},              // R2
    '{1'b0, 8'h44, 4'd4, 64'h0, 1'b1, 64'h0, 4'd4},                      // R4
    '{1'b1, 8'h44, 4'd4, 64'h5, 1'b1, 64'h0, 4'd4},                      // R4
    '{1'b0, 8'hFC, 4'd4, 64'h0, 1'b1, 64'h0, 4'd4},                      // R4
    '{1'b0, 8'h40, 4'd4, 64'h0, 1'b0, 64'h0, 4'd4},                      // R4
    '{1'b1, 8'h10, 4'd4, 64'h30, 1'b0, 64'h0, 4'd9},                     // R9
    '{1'b0, 8'h10, 4'd4, 64'h0, 1'b0, 64'hC0, 4'd9},                     // R9
    '{1'b1, 8'h08, 4'd4, 64'h0, 1'b1, 64'h0, 4'd8},                      // R8
    '{1'b0, 8'h08, 4'd4, 64'h0, 1'b0, 64'h80, 4'd8},                     // R8
    '{1'b1, 8'h04, 4'd4, 64'h0, 1'b1, 64'h0, 4'd8}                       // R8
  };

  logic [63:0] got_data;
  logic        got_err, got_valid;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One request with rsp_ready held high; captures the response after the accepting edge.
  task automatic access(input logic wr, input logic [7:0] off, input logic [3:0] sz,
                        input logic [63:0] wd);
    @(negedge clk);
    req_valid  = 1'b1;
    req_write  = wr;
    req_offset = off;
    req_size   = sz;
    req_wdata  = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    got_valid = rsp_valid;
    got_data  = rsp_rdata;
    got_err   = rsp_err;
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000) begin
        checks++;
        failures++;
        $display("FAIL watchdog actual=%0d expected=done", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    rst = 1'b1;
    req_valid = 1'b0; req_write = 1'b0; req_offset = '0; req_size = 4'd4; req_wdata = '0;
    rsp_ready = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state of the handshake
    check("R1 rsp_valid after reset", {63'h0, rsp_valid}, 64'h0);
    check("R12 req_ready idle", {63'h0, req_ready}, 64'h1);

    for (int v = 0; v < NV; v++) begin
      access(VECS[v].wr, VECS[v].off, VECS[v].size, VECS[v].wdata);
      check($sformatf("R12 valid vec%0d", v), {63'h0, got_valid}, 64'h1);
      check($sformatf("R%0d err vec%0d", VECS[v].req, v), {63'h0, got_err}, {63'h0, VECS[v].err});
      check($sformatf("R%0d data vec%0d", VECS[v].req, v), got_data, VECS[v].rdata);
    end

    // R12: back-pressure holds the response and blocks new requests
    @(negedge clk);
    rsp_ready = 1'b0;
    access(1'b0, 8'h1C, 4'd4, 64'h0);
    check("R12 bp valid", {63'h0, got_valid}, 64'h1);
    req_valid = 1'b1; req_write = 1'b1; req_offset = 8'h1C; req_size = 4'd4;
    req_wdata = 64'h0BAD_0BAD;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R12 bp ready low", {63'h0, req_ready}, 64'h0);
      check("R12 bp data hold", rsp_rdata, 64'hCAFE_F00D);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    check("R12 drained", {63'h0, rsp_valid}, 64'h0);
    access(1'b0, 8'h1C, 4'd4, 64'h0);
    check("R12 blocked write not taken", got_data, 64'hCAFE_F00D);

    // R1: reset mid-run restores cold values
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    access(1'b0, 8'h1C, 4'd4, 64'h0);
    check("R1 reg7 after reset", got_data, 64'h1234_5678);
    access(1'b0, 8'h20, 4'd8, 64'h0);
    check("R1 pad after reset", got_data, 64'h0);
    access(1'b0, 8'h0C, 4'd4, 64'h0);
    check("R1 w1c after reset", got_data, 64'h3);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule